// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's store and load ports and its memory port, and gives the core a total-store-order view. A store is taken into a small circular queue in the cycle it is offered, and the core moves on without waiting for memory. Queued stores leave for memory one at a time, oldest first, through a valid/acknowledge write port. Until a store has been acknowledged there, no other agent can see it.

A load is first compared with every queued store. If any of them has the same address, the youngest such store supplies the data in the same cycle and memory is not read. If none matches, the load goes straight to the memory read port. It can therefore complete ahead of older queued stores to other addresses.

A fence request, held by the core, stalls traffic until the queue is empty. A store fence holds back new stores only. A full fence holds back both stores and loads. Depth and widths are parameters; the depth must be a power of two and at least two.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty: `wr_valid` is 0, `fence_done` is 1 and `st_ready` is 1. With the queue not full and no fence pending, `st_ready` is 1, and a store with `st_valid` high is taken at that clock edge.
- R2: With DEPTH stores queued, `st_ready` is 0. This holds even in a cycle in which the head store is being acknowledged.
- R3: When a load address matches a queued store, `ld_ready` is 1 in the same cycle and `ld_data` carries that store's data. `mrd_valid` stays 0.
- R4: When several queued stores match a load address, `ld_data` comes from the youngest of them.
- R5: A load with no match drives `mrd_valid` high with `mrd_addr` equal to `ld_addr`. It then has `ld_ready` equal to `mrd_ready` and `ld_data` equal to `mrd_data`, whatever older stores to other addresses are queued.
- R6: While the queue is not empty, `wr_valid` is 1 and `wr_addr`/`wr_data` show the oldest queued store. That store stays there until `wr_ack`, and each acknowledged cycle removes exactly one store in program order.
- R7: `fence_done` is 1 exactly when the queue is empty, so no write is outstanding.
- R8: With `fence_req` high, `fence_kind` = 0 (store fence) and the queue not empty, `st_ready` is 0 while loads are still served.
- R9: With `fence_req` high, `fence_kind` = 1 (full fence) and the queue not empty, `st_ready`, `ld_ready` and `mrd_valid` are all 0.
- R10: A load in the same cycle as a store accepted to the same address does not see that store. It is served from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Core issues a load |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | ADDR_W | Load address |
| ld_data | output | DATA_W | Load result |
| mrd_valid | output | 1 | Memory read request |
| mrd_ready | input | 1 | Memory returns data this cycle |
| mrd_addr | output | ADDR_W | Memory read address |
| mrd_data | input | DATA_W | Memory read data |
| wr_valid | output | 1 | Oldest store presented to memory |
| wr_ack | input | 1 | Memory took the presented store |
| wr_addr | output | ADDR_W | Drain address |
| wr_data | output | DATA_W | Drain data |
| fence_req | input | 1 | Fence pending, held until done |
| fence_kind | input | 1 | 0 store fence, 1 full fence |
| fence_done | output | 1 | Queue empty |

## Verification
Two functions can fall in the same cycle and need care.

The first case is a load that forwards from the head store while that store is being acknowledged. It is provoked by holding `wr_ack` low until the queue holds a store to the loaded address, then raising `wr_ack` and the load together. It is judged by `ld_data` still matching the forwarded value. In the next cycle the same load misses and must return the freshly written memory value.

The second case is a store accepted to the address a load reads in the same cycle. Here the load must be served from memory, not from the new store.

A behavioural queue model in the bench predicts every output in every cycle, while random acknowledge and ready patterns keep these overlaps recurring.

// File: rtl/sb_pkg.sv
// Shared types for the ordered store buffer.
package sb_pkg;
    typedef enum logic {
        FENCE_STORE = 1'b0,
        FENCE_FULL  = 1'b1
    } fence_kind_e;
endpackage

// File: rtl/sb_fifo.sv
// Circular queue of pending stores.
// Exposes the entries ordered by age: index 0 is the oldest, higher indices are younger.
// Assumes DEPTH is a power of two, at least 2, and that the caller never pushes when full
// or pops when empty.
module sb_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic                          full,
    output logic                          empty,
    output logic [DEPTH-1:0][ADDR_W-1:0]  age_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  age_data,
    output logic [DEPTH-1:0]              age_live
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DEPTH-1:0][ADDR_W-1:0] addr_mem;
    logic [DEPTH-1:0][DATA_W-1:0] data_mem;
    logic [PTR_W-1:0]             head_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [PTR_W-1:0]             tail;

    assign tail  = head_q + cnt_q[PTR_W-1:0];
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    // Write an accepted store into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail] <= push_addr;
            data_mem[tail] <= push_data;
        end
    end

    // Advance the head and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop) head_q <= head_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Rotate the storage into age order for the forwarding search.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PTR_W-1:0] slot;
        assign slot        = head_q + PTR_W'(k);
        assign age_addr[k] = addr_mem[slot];
        assign age_data[k] = data_mem[slot];
        assign age_live[k] = (CNT_W'(k) < cnt_q);
    end

    a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/sb_fwd.sv
// Load-forwarding search.
// Scans the age-ordered entries from oldest to youngest and keeps the last live match,
// so the youngest matching store supplies the data. Purely combinational.
module sb_fwd #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  age_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  age_data,
    input  logic [DEPTH-1:0]              age_live,
    output logic                          hit,
    output logic [DATA_W-1:0]             fwd_data
);
    // Priority search in which younger entries override older ones.
    always_comb begin
        hit      = 1'b0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_live[k] && (age_addr[k] == ld_addr)) begin
                hit      = 1'b1;
                fwd_data = age_data[k];
            end
        end
    end
endmodule

// File: rtl/tso_store_buffer.sv
// Store buffer giving total-store-order behaviour between a core and memory.
// Stores are accepted at once and drained oldest first. Loads forward from the youngest
// matching store or bypass to memory. Fences stall until the queue is empty.
// Assumes the core holds fence_req until fence_done, and that the memory read port
// returns data in the cycle mrd_ready is high.
module tso_store_buffer #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic [DATA_W-1:0] mrd_data,
    output logic              wr_valid,
    input  logic              wr_ack,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              fence_req,
    input  logic              fence_kind,
    output logic              fence_done
);
    import sb_pkg::*;

    logic                          push, pop, full, empty, hit;
    logic                          fence_hold, load_hold;
    logic [DATA_W-1:0]             fwd_data;
    logic [DEPTH-1:0][ADDR_W-1:0]  age_addr;
    logic [DEPTH-1:0][DATA_W-1:0]  age_data;
    logic [DEPTH-1:0]              age_live;
    fence_kind_e                   kind;

    assign kind = fence_kind_e'(fence_kind);

    sb_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr), .push_data(st_data),
        .pop(pop), .full(full), .empty(empty),
        .age_addr(age_addr), .age_data(age_data), .age_live(age_live)
    );

    sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fwd (
        .ld_addr(ld_addr), .age_addr(age_addr), .age_data(age_data), .age_live(age_live),
        .hit(hit), .fwd_data(fwd_data)
    );

    // Fence gating: every fence holds stores back, and a full fence also holds loads.
    always_comb begin
        fence_hold = fence_req && !empty;
        load_hold  = fence_hold && (kind == FENCE_FULL);
    end

    // Store port: accept unless the queue is full or a fence is pending.
    always_comb begin
        st_ready = !full && !fence_hold;
        push     = st_valid && st_ready;
    end

    // Load port: forward on a hit, otherwise bypass to the memory read port.
    always_comb begin
        mrd_valid = ld_valid && !hit && !load_hold;
        mrd_addr  = ld_addr;
        ld_ready  = !load_hold && (hit || mrd_ready);
        ld_data   = hit ? fwd_data : mrd_data;
    end

    // Drain port: present the oldest entry until memory acknowledges it.
    always_comb begin
        wr_valid   = !empty;
        wr_addr    = age_addr[0];
        wr_data    = age_data[0];
        pop        = wr_valid && wr_ack;
        fence_done = empty;
    end

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    a_r1_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> wr_valid);
    a_r9_full_fence_blocks_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && fence_kind && !fence_done) |-> (!ld_ready && !mrd_valid && !st_ready));
    a_r8_fence_blocks_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && !fence_done) |-> !st_ready);
    a_r3_hit_skips_memory: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && !mrd_valid && !load_hold) |-> hit);
endmodule

// File: tb/test_tso_store_buffer.sv
module test_tso_store_buffer;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, mrd_ready = 0, wr_ack = 0, fence_req = 0, fence_kind = 0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic st_ready, ld_ready, mrd_valid, wr_valid, fence_done;
    logic [ADDR_W-1:0] mrd_addr, wr_addr;
    logic [DATA_W-1:0] ld_data, mrd_data, wr_data;

    logic [DATA_W-1:0] mem [256];
    assign mrd_data = mem[mrd_addr];

    typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } ent_t;
    ent_t q[$];

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tso_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tso_store_buffer (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_data(ld_data), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrd_data(mrd_data), .wr_valid(wr_valid), .wr_ack(wr_ack), .wr_addr(wr_addr),
        .wr_data(wr_data), .fence_req(fence_req), .fence_kind(fence_kind), .fence_done(fence_done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, compare against the queue model, update at posedge.
    task automatic cycle(bit sv, logic [ADDR_W-1:0] sa, logic [DATA_W-1:0] sd,
                         bit lv, logic [ADDR_W-1:0] la, bit ack, bit rdy, bit fr, bit fk,
                         string ldtag = "");
        int n, nm;
        bit full, empty, fblk, lblk, hit, e_st, e_ld;
        logic [DATA_W-1:0] fwd;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; ld_valid = lv; ld_addr = la;
        wr_ack = ack; mrd_ready = rdy; fence_req = fr; fence_kind = fk;
        #2;
        n = q.size(); full = (n == DEPTH); empty = (n == 0);
        fblk = fr && !empty; lblk = fblk && fk;
        hit = 0; nm = 0; fwd = '0;
        foreach (q[i]) if (q[i].a == la) begin hit = 1; nm++; fwd = q[i].d; end
        e_st = !full && !fblk;
        e_ld = !lblk && (hit || rdy);
        chk(fblk ? (fk ? "R9" : "R8") : (full ? "R2" : "R1"), st_ready, e_st, "st_ready");
        chk("R7", fence_done, empty, "fence_done");
        chk("R6", wr_valid, !empty, "wr_valid");
        if (!empty) begin
            chk("R6", wr_addr, q[0].a, "wr_addr");
            chk("R6", wr_data, q[0].d, "wr_data");
        end
        if (lv) begin
            chk(lblk ? "R9" : (hit ? "R3" : "R5"), ld_ready, e_ld, "ld_ready");
            chk(lblk ? "R9" : (hit ? "R3" : "R5"), mrd_valid, !hit && !lblk, "mrd_valid");
            if (!hit && !lblk) chk("R5", mrd_addr, la, "mrd_addr");
            if (e_ld)
                chk(ldtag != "" ? ldtag : (hit ? (nm > 1 ? "R4" : "R3") : "R5"),
                    ld_data, hit ? fwd : mem[la], "ld_data");
        end
        @(posedge clk);
        cycles++;
        if (!empty && ack) begin mem[q[0].a] = q[0].d; void'(q.pop_front()); end
        if (sv && e_st) q.push_back('{a: sa, d: sd});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DATA_W'(i * 37 + 5);
        // Reset state (R1)
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(negedge clk); #2;
        chk("R1", wr_valid, 0, "wr_valid after reset");
        chk("R1", fence_done, 1, "fence_done after reset");
        chk("R1", st_ready, 1, "st_ready after reset");
        @(negedge clk); rst_n = 1;

        // Fill to full without acks, then try one more store (R2)
        for (int i = 0; i < DEPTH; i++) cycle(1, 8'(16 + i), 16'(100 + i), 0, 0, 0, 1, 0, 0);
        cycle(1, 8'h50, 16'h5555, 0, 0, 0, 1, 0, 0);
        // Full and acked in the same cycle: still refused (R2)
        cycle(1, 8'h51, 16'h6666, 0, 0, 1, 1, 0, 0);
        // Miss while older stores pend (R5)
        cycle(0, 0, 0, 1, 8'h03, 0, 1, 0, 0);
        cycle(0, 0, 0, 1, 8'h04, 0, 0, 0, 0);
        // Drain all (R6)
        for (int i = 0; i < DEPTH; i++) cycle(0, 0, 0, 0, 0, 1, 1, 0, 0);

        // Youngest of several matches (R4)
        cycle(1, 8'h20, 16'hA001, 0, 0, 0, 1, 0, 0);
        cycle(1, 8'h21, 16'hA002, 0, 0, 0, 1, 0, 0);
        cycle(1, 8'h20, 16'hA003, 1, 8'h20, 0, 1, 0, 0);
        cycle(0, 0, 0, 1, 8'h20, 0, 1, 0, 0, "R4");
        // Forward from the head while it is acknowledged, then read memory (R3)
        cycle(0, 0, 0, 1, 8'h21, 0, 1, 0, 0, "R3");
        cycle(0, 0, 0, 1, 8'h20, 1, 1, 0, 0, "R4");
        cycle(0, 0, 0, 1, 8'h21, 1, 1, 0, 0, "R3");
        cycle(0, 0, 0, 1, 8'h21, 1, 1, 0, 0, "R5");
        // Same-cycle store and load to one address (R10)
        cycle(1, 8'h30, 16'hBEEF, 1, 8'h30, 0, 1, 0, 0, "R10");
        // Store fence: stores held, loads served (R8)
        cycle(1, 8'h31, 16'h1111, 1, 8'h30, 0, 1, 1, 0);
        cycle(0, 0, 0, 1, 8'h05, 1, 1, 1, 0);
        cycle(1, 8'h32, 16'h2222, 0, 0, 0, 1, 1, 0);
        // Full fence: loads held too (R9)
        cycle(0, 0, 0, 1, 8'h32, 0, 1, 1, 1);
        cycle(1, 8'h33, 16'h3333, 1, 8'h07, 1, 1, 1, 1);
        cycle(1, 8'h34, 16'h4444, 1, 8'h07, 0, 1, 1, 1);

        // Random traffic with a small address range for frequent hits
        for (int i = 0; i < 4000; i++) begin
            bit fr;
            fr = ($urandom % 16) == 0;
            cycle($urandom % 2, 8'($urandom % 6), 16'($urandom), $urandom % 2,
                  8'($urandom % 6), ($urandom % 3) == 0, ($urandom % 4) != 0, fr, $urandom % 2);
        end
        summary();
    end

    initial begin
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
        summary();
    end
endmodule